// File: doc/BRIEF.md
# Burst-Gating Bus Master with Write Error Folding

This block is the bus-side engine of a data-FIFO master. It takes one request at a time from the FIFO side, either a single beat or a four-beat burst, each carrying a crossbar slave index. A 32-bit control word decides, per slave and per direction, whether a burst may be issued on the bus as one burst. A disallowed burst is broken into four single-beat accesses on consecutive addresses.

For an allowed write burst, the block first pulls the first half of the data (two beats) from the FIFO. It then returns an early, always-clean completion for that half, so the FIFO side can go on to supply the second half. After that it writes all four beats. The real outcome of the first half is either thrown away or folded into the final response, as a control bit selects.

Every data path uses a valid/ready handshake. Each side may hold its valid signal high for as long as it likes. The block keeps `bus_valid`, `bus_addr` and `bus_wdata` stable until `bus_ready` is sampled high. It keeps `rsp_valid` and the response fields stable until `rsp_ready` is sampled high. It raises `wdat_ready` only in the cycles in which it can store a beat. Only one beat is outstanding on the bus at a time: the next beat is not offered before `bus_rvalid` returns.

Top module: `burst_gate_master`

## Requirements
- R1: The control word resets to zero. Word bits 31..21 read back as written, and bits 20..0 always read as zero. Bit 31 is the most significant bit.
- R2: A read burst to slave s is issued as a burst only when word bit 31-s and the global read enable at word bit 23 are both 1. It then appears as four beats with `bus_burst`=1, at addresses base, base+4, base+8 and base+12.
- R3: A write burst to slave s is issued as a burst only when word bit 31-s and the global write enable at word bit 22 are both 1.
- R4: A burst that is not allowed is issued as four beats with `bus_burst`=0, at the same four consecutive addresses.
- R5: For an allowed write burst, two data beats are taken from the FIFO side and a response with `rsp_last`=0 and `rsp_err`=0 is given before any bus beat is offered.
- R6: With the fold bit (word bit 21) at 0, the final response of an allowed write burst reports only errors from beats 2 and 3.
- R7: With the fold bit at 1, the final response of an allowed write burst reports an error if any of its four beats erred, even if beats 2 and 3 were clean.
- R8: The folded error state is cleared when each new write burst is accepted, so an error in one burst never shows in the next one.
- R9: Every read beat returns its own response, carrying `bus_rdata` and that beat's error. `rsp_last`=1 is set on the final beat only.
- R10: A single-beat request (`req_burst`=0) makes one bus beat with `bus_burst`=0 and one response with `rsp_last`=1.
- R11: Write data reaches the bus in the order it was taken from the FIFO side, and it is held stable while `bus_ready` is low.
- R12: `req_ready` is high only when no transaction is in progress. A split write returns one response carrying the OR of its four beat errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word read value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_slave | input | 3 | Crossbar slave index |
| req_addr | input | AW | Start address |
| wdat_valid | input | 1 | FIFO write beat offered |
| wdat_ready | output | 1 | FIFO write beat taken |
| wdat_data | input | DW | FIFO write beat |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Response error flag |
| rsp_last | output | 1 | Final response of the transaction |
| rsp_rdata | output | DW | Read data (zero for writes) |
| bus_valid | output | 1 | Bus beat offered |
| bus_ready | input | 1 | Bus beat accepted |
| bus_write | output | 1 | Bus beat direction |
| bus_burst | output | 1 | Beat belongs to a bus burst |
| bus_slave | output | 3 | Target slave index |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Beat write data |
| bus_rvalid | input | 1 | Beat completion from the bus |
| bus_rdata | input | DW | Beat read data |
| bus_err | input | 1 | Beat error, valid with bus_rvalid |

## Verification
The bench builds the block with its defaults: 32-bit address and data and four-beat bursts, so each half is two beats and addresses step by 4. With these values, every beat of a burst can be given its own injected error by address, which makes error placement in each half, folding, discard and per-beat read errors all reachable. The slave bits used are 0, 2 and 7, which cover both ends of the per-slave field and one slave in the middle.

// File: rtl/bgm_pkg.sv
package bgm_pkg;
  localparam int CFG_W   = 32;
  localparam int NSLV    = 8;
  localparam int SLV_W   = 3;
  localparam int RD_POS  = CFG_W - 1 - NSLV;
  localparam int WR_POS  = RD_POS - 1;
  localparam int ACC_POS = WR_POS - 1;
  localparam int KEEP_W  = CFG_W - ACC_POS;

  function automatic int slv_pos(int s);
    return CFG_W - 1 - s;
  endfunction

  typedef struct packed {
    logic [NSLV-1:0] slv_en;
    logic            rd_en;
    logic            wr_en;
    logic            fold;
  } cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_GATH, S_EARLY, S_FETCH, S_SEND, S_WAIT, S_RSP
  } st_t;
endpackage

// File: rtl/bgm_cfg.sv
module bgm_cfg
  import bgm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg
);
  logic [KEEP_W-1:0] keep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  keep_q <= '0;
    else if (we) keep_q <= wdata[CFG_W-1:ACC_POS];
  end

  assign rdata = {keep_q, {ACC_POS{1'b0}}};

  for (genvar s = 0; s < NSLV; s++) begin : g_slv
    assign cfg.slv_en[s] = rdata[slv_pos(s)];
  end
  assign cfg.rd_en = rdata[RD_POS];
  assign cfg.wr_en = rdata[WR_POS];
  assign cfg.fold  = rdata[ACC_POS];
endmodule

// File: rtl/bgm_policy.sv
module bgm_policy
  import bgm_pkg::*;
(
  input  cfg_t             cfg,
  input  logic             is_write,
  input  logic [SLV_W-1:0] slave,
  output logic             burst_ok
);
  logic [NSLV-1:0] ok_rd, ok_wr;

  for (genvar s = 0; s < NSLV; s++) begin : g_gate
    assign ok_rd[s] = cfg.slv_en[s] & cfg.rd_en;
    assign ok_wr[s] = cfg.slv_en[s] & cfg.wr_en;
  end

  assign burst_ok = is_write ? ok_wr[slave] : ok_rd[slave];
endmodule

// File: rtl/bgm_seq.sv
module bgm_seq
  import bgm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_burst,
  input  logic [SLV_W-1:0] req_slave,
  input  logic [AW-1:0]    req_addr,
  input  logic             burst_ok,
  input  logic             fold,
  input  logic             wdat_valid,
  output logic             wdat_ready,
  input  logic [DW-1:0]    wdat_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_err,
  output logic             rsp_last,
  output logic [DW-1:0]    rsp_rdata,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_write,
  output logic             bus_burst,
  output logic [SLV_W-1:0] bus_slave,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_rvalid,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_err,
  output logic             cur_write
);
  localparam int HALF = BEATS / 2;
  localparam int BW   = $clog2(BEATS);
  localparam int SH   = $clog2(DW / 8);

  st_t              state;
  logic             t_write, t_multi, t_ok;
  logic [SLV_W-1:0] t_slave;
  logic [AW-1:0]    t_addr;
  logic [BW-1:0]    beat, gidx, last_beat;
  logic [BW:0]      beat_nx;
  logic [DW-1:0]    hbuf [BEATS];
  logic [DW-1:0]    wreg, rsp_data_q;
  logic             err_h1, err_h2, err_any, rsp_err_q, rsp_last_q;
  logic             in_h1, fold_err;

  assign last_beat = t_multi ? BW'(BEATS - 1) : '0;
  assign beat_nx   = {1'b0, beat} + 1'b1;
  assign in_h1     = ({1'b0, beat} < (BW + 1)'(HALF));
  assign fold_err  = t_ok ? (err_h2 | bus_err | (fold & err_h1))
                          : (err_any | bus_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      t_write    <= 1'b0;
      t_multi    <= 1'b0;
      t_ok       <= 1'b0;
      t_slave    <= '0;
      t_addr     <= '0;
      beat       <= '0;
      gidx       <= '0;
      wreg       <= '0;
      rsp_data_q <= '0;
      err_h1     <= 1'b0;
      err_h2     <= 1'b0;
      err_any    <= 1'b0;
      rsp_err_q  <= 1'b0;
      rsp_last_q <= 1'b0;
      for (int i = 0; i < BEATS; i++) hbuf[i] <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          t_write <= req_write;
          t_multi <= req_burst;
          t_ok    <= req_burst & burst_ok;
          t_slave <= req_slave;
          t_addr  <= req_addr;
          beat    <= '0;
          gidx    <= '0;
          err_h1  <= 1'b0;   // fresh error state per transaction (R8)
          err_h2  <= 1'b0;
          err_any <= 1'b0;
          if (!req_write)                  state <= S_SEND;
          else if (req_burst && burst_ok)  state <= S_GATH;
          else                             state <= S_FETCH;
        end
        S_GATH: if (wdat_valid) begin
          hbuf[gidx] <= wdat_data;
          gidx       <= gidx + 1'b1;
          if (gidx == BW'(HALF - 1)) state <= S_EARLY;
        end
        S_EARLY: if (rsp_ready) state <= S_SEND;
        S_FETCH: if (wdat_valid) begin
          wreg  <= wdat_data;
          state <= S_SEND;
        end
        S_SEND: if (bus_ready) state <= S_WAIT;
        S_WAIT: if (bus_rvalid) begin
          if (t_write) begin
            err_any <= err_any | bus_err;
            if (t_ok && in_h1) err_h1 <= err_h1 | bus_err;
            if (t_ok && !in_h1) err_h2 <= err_h2 | bus_err;
            if (beat == last_beat) begin
              rsp_err_q  <= fold_err;
              rsp_last_q <= 1'b1;
              rsp_data_q <= '0;
              state      <= S_RSP;
            end else begin
              beat  <= beat_nx[BW-1:0];
              state <= (t_ok && beat_nx < (BW + 1)'(HALF)) ? S_SEND : S_FETCH;
            end
          end else begin
            rsp_err_q  <= bus_err;
            rsp_data_q <= bus_rdata;
            rsp_last_q <= (beat == last_beat);
            state      <= S_RSP;
          end
        end
        S_RSP: if (rsp_ready) begin
          if (rsp_last_q) state <= S_IDLE;
          else begin
            beat  <= beat_nx[BW-1:0];
            state <= S_SEND;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign wdat_ready = (state == S_GATH) || (state == S_FETCH);
  assign rsp_valid  = (state == S_EARLY) || (state == S_RSP);
  assign rsp_err    = (state == S_RSP) && rsp_err_q;
  assign rsp_last   = (state == S_RSP) && rsp_last_q;
  assign rsp_rdata  = (state == S_RSP) ? rsp_data_q : '0;
  assign bus_valid  = (state == S_SEND);
  assign bus_write  = t_write;
  assign bus_burst  = t_ok;
  assign bus_slave  = t_slave;
  assign bus_addr   = t_addr + (AW'(beat) << SH);
  assign bus_wdata  = (t_ok && in_h1) ? hbuf[beat] : wreg;
  assign cur_write  = t_write;
endmodule

// File: rtl/burst_gate_master.sv
module burst_gate_master
  import bgm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_burst,
  input  logic [2:0]       req_slave,
  input  logic [AW-1:0]    req_addr,
  input  logic             wdat_valid,
  output logic             wdat_ready,
  input  logic [DW-1:0]    wdat_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_err,
  output logic             rsp_last,
  output logic [DW-1:0]    rsp_rdata,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_write,
  output logic             bus_burst,
  output logic [2:0]       bus_slave,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_rvalid,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_err
);
  cfg_t cfg;
  logic burst_ok;
  logic cur_write;

  bgm_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  bgm_policy u_pol (
    .cfg(cfg), .is_write(req_write), .slave(req_slave), .burst_ok(burst_ok)
  );

  bgm_seq #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_burst(req_burst), .req_slave(req_slave), .req_addr(req_addr),
    .burst_ok(burst_ok), .fold(cfg.fold),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_last(rsp_last), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_burst(bus_burst), .bus_slave(bus_slave), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .cur_write(cur_write)
  );
endmodule

// File: rtl/bgm_chk.sv
module bgm_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   cfg_rdata,
  input logic          req_ready,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_write,
  input logic          bus_burst,
  input logic [2:0]    bus_slave,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_err,
  input logic          rsp_last,
  input logic          cur_write
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[20:0] == 21'd0);

  // R2
  rd_burst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_burst && !bus_write) |->
      (cfg_rdata[23] && cfg_rdata[5'd31 - {2'b00, bus_slave}]));

  // R3
  wr_burst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_burst && bus_write) |->
      (cfg_rdata[22] && cfg_rdata[5'd31 - {2'b00, bus_slave}]));

  // R5
  early_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last && cur_write) |-> !rsp_err);

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_wdata)));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_err) && $stable(rsp_last)));

  // R12
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, bus_valid, rsp_valid}));
endmodule

bind burst_gate_master bgm_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .req_ready(req_ready),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
  .bus_burst(bus_burst), .bus_slave(bus_slave), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_err(rsp_err), .rsp_last(rsp_last), .cur_write(cur_write)
);

// File: tb/tb_burst_gate_master.sv
module tb_burst_gate_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RMIX = 32'h5A5A_0000;

  typedef struct packed {
    logic [31:0] cfg;
    logic        wr;
    logic        bu;
    logic [2:0]  slv;
    logic [3:0]  mask;
    logic [3:0]  nbus;
    logic        bb;
    logic [3:0]  nrsp;
    logic [3:0]  rerr;
    logic        early;
    logic [3:0]  tag;
  } vec_t;

  // cfg: slave s enable = bit 31-s, read enable = bit 23, write enable = bit 22, fold = bit 21
  localparam vec_t VEC [12] = '{
    '{32'h2080_0000, 1'b0, 1'b1, 3'd2, 4'b0000, 4'd4, 1'b1, 4'd4, 4'b0000, 1'b0, 4'd2},  // R2 allowed read
    '{32'h2000_0000, 1'b0, 1'b1, 3'd2, 4'b0000, 4'd4, 1'b0, 4'd4, 4'b0000, 1'b0, 4'd4},  // R4 global read off
    '{32'h8080_0000, 1'b0, 1'b1, 3'd2, 4'b0000, 4'd4, 1'b0, 4'd4, 4'b0000, 1'b0, 4'd2},  // R2 slave bit off
    '{32'h2080_0000, 1'b0, 1'b1, 3'd2, 4'b0100, 4'd4, 1'b1, 4'd4, 4'b0100, 1'b0, 4'd9},  // R9 read beat error
    '{32'h2040_0000, 1'b1, 1'b1, 3'd2, 4'b0000, 4'd4, 1'b1, 4'd2, 4'b0000, 1'b1, 4'd5},  // R5 early ack
    '{32'h2040_0000, 1'b1, 1'b1, 3'd2, 4'b0001, 4'd4, 1'b1, 4'd2, 4'b0000, 1'b1, 4'd6},  // R6 drop half-1 err
    '{32'h2060_0000, 1'b1, 1'b1, 3'd2, 4'b0010, 4'd4, 1'b1, 4'd2, 4'b0010, 1'b1, 4'd7},  // R7 fold half-1 err
    '{32'h2040_0000, 1'b1, 1'b1, 3'd2, 4'b1000, 4'd4, 1'b1, 4'd2, 4'b0010, 1'b1, 4'd6},  // R6 half-2 err kept
    '{32'h2080_0000, 1'b1, 1'b1, 3'd2, 4'b0100, 4'd4, 1'b0, 4'd1, 4'b0001, 1'b0, 4'd3},  // R3 R12 split write
    '{32'hFFE0_0000, 1'b1, 1'b0, 3'd2, 4'b0001, 4'd1, 1'b0, 4'd1, 4'b0001, 1'b0, 4'd10}, // R10 single write
    '{32'hFFE0_0000, 1'b0, 1'b0, 3'd7, 4'b0000, 4'd1, 1'b0, 4'd1, 4'b0000, 1'b0, 4'd10}, // R10 single read
    '{32'h0160_0000, 1'b1, 1'b1, 3'd7, 4'b0000, 4'd4, 1'b1, 4'd2, 4'b0000, 1'b1, 4'd3}   // R3 slave 7 burst
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_burst = 1'b0;
  logic [2:0] req_slave = '0;
  logic [31:0] req_addr = '0;
  logic wdat_valid = 1'b1, wdat_ready;
  logic [31:0] wdat_data;
  logic rsp_valid, rsp_ready = 1'b1, rsp_err, rsp_last;
  logic [31:0] rsp_rdata;
  logic bus_valid, bus_ready = 1'b1, bus_write, bus_burst;
  logic [2:0] bus_slave;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_rvalid, bus_err;
  logic [31:0] bus_rdata;

  int errors = 0, checks = 0;
  logic [31:0] cur_base = '0;
  logic [3:0]  cur_mask = '0;
  logic        cur_wr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_gate_master dut (.*);

  // bus slave model: completes each beat one cycle after acceptance
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_rvalid <= bus_valid && bus_ready;
      bus_err    <= bus_valid && bus_ready && cur_mask[bus_addr[3:2]];
      bus_rdata  <= bus_addr ^ RMIX;
    end
  end

  // FIFO model: sequential values
  always @(posedge clk) begin
    if (!rst_n) wdat_data <= 32'hD000_0000;
    else if (wdat_valid && wdat_ready) wdat_data <= wdat_data + 1;
  end

  // monitor
  logic [3:0] nb, np, nr, nb_f, np_f, rerr_seen;
  logic bb_and, bb_or, addr_bad, rd_bad;
  logic [31:0] pops [8];
  logic [31:0] wds  [8];
  int done_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) begin
        nb = 0; np = 0; nr = 0; nb_f = 4'hF; np_f = 4'hF; rerr_seen = 0;
        bb_and = 1; bb_or = 0; addr_bad = 0; rd_bad = 0;
      end
      if (wdat_valid && wdat_ready) begin
        pops[np[2:0]] = wdat_data; np = np + 1;
      end
      if (bus_valid && bus_ready) begin
        if (bus_addr != cur_base + {26'd0, nb, 2'b00}) addr_bad = 1;
        wds[nb[2:0]] = bus_wdata;
        bb_and = bb_and & bus_burst; bb_or = bb_or | bus_burst;
        nb = nb + 1;
      end
      if (rsp_valid && rsp_ready) begin
        if (nr == 0) begin nb_f = nb; np_f = np; end
        rerr_seen[nr[1:0]] = rsp_err;
        if (!cur_wr && rsp_rdata != ((cur_base + {26'd0, nr, 2'b00}) ^ RMIX)) rd_bad = 1;
        nr = nr + 1;
        if (rsp_last) done_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input int tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] cfg, input logic wr, input logic bu,
                     input logic [2:0] slv, input logic [3:0] mask,
                     input logic [3:0] xnb, input logic xbb, input logic [3:0] xnr,
                     input logic [3:0] xerr, input logic early, input int tag,
                     input int idx);
    int d0;
    @(negedge clk);
    cfg_we = 1; cfg_wdata = cfg;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_rdata == (cfg & 32'hFFE0_0000), 1, "cfg readback", cfg_rdata, cfg & 32'hFFE0_0000); // R1
    cur_base = 32'h1000_0000 + (idx << 8); cur_mask = mask; cur_wr = wr;
    d0 = done_cnt;
    req_valid = 1; req_write = wr; req_burst = bu; req_slave = slv; req_addr = cur_base;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, 12, "req_ready busy", {31'd0, req_ready}, 0);   // R12
    while (done_cnt == d0) @(negedge clk);
    chk(nb == xnb, tag, "bus beats", {28'd0, nb}, {28'd0, xnb});
    chk(bb_and == xbb && bb_or == xbb, tag, "bus_burst", {30'd0, bb_or, bb_and}, {30'd0, xbb, xbb});
    chk(!addr_bad, 4, "beat addresses", {31'd0, addr_bad}, 0);            // R4 R2
    chk(nr == xnr, tag, "responses", {28'd0, nr}, {28'd0, xnr});
    chk(rerr_seen == xerr, tag, "response errors", {28'd0, rerr_seen}, {28'd0, xerr});
    if (wr) begin
      for (int k = 0; k < 4; k++)
        if (k < int'(nb)) chk(wds[k] == pops[k], 11, "write data order", wds[k], pops[k]); // R11
    end else
      chk(!rd_bad, 9, "read data", {31'd0, rd_bad}, 0);                     // R9
    if (early)
      chk(nb_f == 0 && np_f == 2, 5, "early ack point", {24'd0, nb_f, np_f}, 32'h02); // R5
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 0, 1, "reset cfg", cfg_rdata, 0);
    chk(req_ready && !rsp_valid && !bus_valid && !wdat_ready, 12, "reset idle",
        {28'd0, req_ready, rsp_valid, bus_valid, wdat_ready}, 32'h8);
    rst_n = 1;
    @(negedge clk);
    // R1 reserved bits
    cfg_we = 1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_rdata == 32'hFFE0_0000, 1, "reserved zero", cfg_rdata, 32'hFFE0_0000);
    for (int i = 0; i < 12; i++)
      run(VEC[i].cfg, VEC[i].wr, VEC[i].bu, VEC[i].slv, VEC[i].mask, VEC[i].nbus,
          VEC[i].bb, VEC[i].nrsp, VEC[i].rerr, VEC[i].early, int'(VEC[i].tag), i);
    // R8: errored folded burst, then clean burst must report clean
    run(32'h2060_0000, 1, 1, 3'd2, 4'b0001, 4'd4, 1, 4'd2, 4'b0010, 1, 7, 12);
    run(32'h2060_0000, 1, 1, 3'd2, 4'b0000, 4'd4, 1, 4'd2, 4'b0000, 1, 8, 13);
    // R12: split write with error in every beat reports one error
    run(32'h0000_0000, 1, 1, 3'd0, 4'b1111, 4'd4, 0, 4'd1, 4'b0001, 0, 12, 14);
    // R6 vs R7 on slave 0 with half-1 error only
    run(32'h8040_0000, 1, 1, 3'd0, 4'b0011, 4'd4, 1, 4'd2, 4'b0000, 1, 6, 15);
    run(32'h8060_0000, 1, 1, 3'd0, 4'b0011, 4'd4, 1, 4'd2, 4'b0010, 1, 7, 16);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule